// File: doc/BRIEF.md
# RV64 Integer Execute Unit with Word Operations

This block is the integer arithmetic and logic stage of a 64-bit RISC-style core. Each cycle it may accept one operation. An operation is given as a 7-bit major opcode, a 3-bit minor function field and a 7-bit extended function field, together with two source register values, a sign-extended 64-bit immediate and the program counter. One cycle later the block presents the destination value and a flag that marks the encoding as unsupported.

The unit handles two families of operations. The first is the full-width register-immediate and register-register family. The second is the 32-bit "word" family, which works on the low half of the first source and sign-extends its 32-bit result to 64 bits. The unit also handles the load-upper-immediate and PC-relative-add forms. Memory access, branches, multiply/divide and the register file belong to other blocks.

Top module: `rv_exec_unit`

## Requirements
- R1: After a synchronous reset, `res_valid`, `res_data` and `res_illegal` are all 0. An operation presented with `op_valid` high appears on the outputs, with `res_valid` high, exactly one clock later.
- R2: Opcode 0x13 selects an immediate operation by minor function. The codes are 0 add, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 shift right, 6 or and 7 and.
- R3: Opcode 0x33 uses the same minor-function map with rs2 as the second operand, and extended function 0. Extended function 0x20 is legal only with minor 0 (subtract) and minor 5 (arithmetic shift right).
- R4: Full-width shifts use a 6-bit amount, taken from imm[5:0] or from rs2[5:0]. Higher rs2 bits are ignored.
- R5: For full-width immediate right shifts, imm[10] selects logical (0) or arithmetic (1). For both immediate shift directions, any other nonzero bit in imm[11:6] makes the operation illegal. Shift left also requires imm[10] to be 0.
- R6: Less-than results are 0 or 1, zero-extended. The unsigned immediate compare treats the sign-extended immediate as an unsigned 64-bit value.
- R7: Opcodes 0x1b (immediate) and 0x3b (register) support only add (plus subtract for register), shift left and the two right shifts. They use a 5-bit amount and sign-extend the 32-bit result. For the immediate form, imm[11:5] must be 0, or 0x20 for an arithmetic right shift.
- R8: Opcode 0x37 returns the immediate unchanged. Opcode 0x17 returns PC plus immediate.
- R9: Any other opcode, minor or extended function combination sets `res_illegal` to 1 and `res_data` to 0.
- R10: While `op_valid` is low, `res_valid` goes low and `res_data` and `res_illegal` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 7 | Major opcode |
| op_minor | input | 3 | Minor function field |
| op_ext | input | 7 | Extended function field |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| imm | input | 64 | Sign-extended immediate |
| pc | input | 64 | Program counter of the operation |
| res_valid | output | 1 | Result present |
| res_data | output | 64 | Destination value |
| res_illegal | output | 1 | Unsupported encoding flag |

## Verification
The hardest cases to reach are word shifts and word arithmetic where bit 31 of the 32-bit result differs from bits 63:32 of the source. Only in those cases does a missing sign extension, or a shift amount that uses bit 5, show up at the outputs. The stimulus therefore pairs sources whose upper halves disagree with their low-half sign, and uses shift amounts whose bit 5 is set. It also uses immediate shift encodings that set single stray bits in imm[11:5], to reach each illegal shift pattern one at a time. A pseudo-random sweep then covers the rest of the encoding space, and a bench-side reference model predicts every result.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_IMM_W  = 7'h1b;
  localparam logic [6:0] OPC_REG_W  = 7'h3b;
  localparam logic [6:0] OPC_UPPER  = 7'h37;
  localparam logic [6:0] OPC_PCREL  = 7'h17;
  localparam logic [6:0] EXT_ALT    = 7'h20;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SLL, K_SLT, K_SLTU, K_XOR,
    K_SRL, K_SRA, K_OR, K_AND, K_PASS, K_NONE
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      word;
    logic      use_imm;
    logic      use_pc;
    logic      illegal;
  } alu_ctl_t;
endpackage

// File: rtl/rv_exec_decode.sv
module rv_exec_decode
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0]      code,
  input  logic [2:0]      minor,
  input  logic [6:0]      ext,
  input  logic [XLEN-1:0] imm,
  output alu_ctl_t        ctl
);
  localparam int SHW = $clog2(XLEN);

  alu_kind_e base_kind;
  logic [6:0] imm_hi_w;
  logic [5:0] imm_hi_d;

  assign imm_hi_w = imm[11:5];
  assign imm_hi_d = imm[11:SHW];

  always_comb begin
    case (minor)
      3'd0: base_kind = K_ADD;
      3'd1: base_kind = K_SLL;
      3'd2: base_kind = K_SLT;
      3'd3: base_kind = K_SLTU;
      3'd4: base_kind = K_XOR;
      3'd5: base_kind = K_SRL;
      3'd6: base_kind = K_OR;
      default: base_kind = K_AND;
    endcase
  end

  always_comb begin
    ctl = '{kind: K_NONE, word: 1'b0, use_imm: 1'b0, use_pc: 1'b0, illegal: 1'b1};
    case (code)
      OPC_IMM: begin
        ctl.use_imm = 1'b1;
        ctl.kind    = base_kind;
        ctl.illegal = 1'b0;
        if (minor == 3'd1 && imm_hi_d != 6'h00) ctl.illegal = 1'b1;
        if (minor == 3'd5) begin
          if (imm_hi_d == 6'h10)      ctl.kind = K_SRA;
          else if (imm_hi_d != 6'h00) ctl.illegal = 1'b1;
        end
      end
      OPC_REG: begin
        ctl.kind = base_kind;
        if (ext == 7'h00) ctl.illegal = 1'b0;
        else if (ext == EXT_ALT && minor == 3'd0) begin
          ctl.kind = K_SUB; ctl.illegal = 1'b0;
        end else if (ext == EXT_ALT && minor == 3'd5) begin
          ctl.kind = K_SRA; ctl.illegal = 1'b0;
        end
      end
      OPC_IMM_W: begin
        ctl.use_imm = 1'b1;
        ctl.word    = 1'b1;
        ctl.kind    = base_kind;
        case (minor)
          3'd0: ctl.illegal = 1'b0;
          3'd1: ctl.illegal = (imm_hi_w != 7'h00);
          3'd5: begin
            if (imm_hi_w == EXT_ALT) begin
              ctl.kind = K_SRA; ctl.illegal = 1'b0;
            end else ctl.illegal = (imm_hi_w != 7'h00);
          end
          default: ctl.illegal = 1'b1;
        endcase
      end
      OPC_REG_W: begin
        ctl.word = 1'b1;
        ctl.kind = base_kind;
        if (minor == 3'd0 || minor == 3'd1 || minor == 3'd5) begin
          if (ext == 7'h00) ctl.illegal = 1'b0;
          else if (ext == EXT_ALT && minor != 3'd1) begin
            ctl.kind    = (minor == 3'd0) ? K_SUB : K_SRA;
            ctl.illegal = 1'b0;
          end
        end
      end
      OPC_UPPER: begin
        ctl.kind = K_PASS; ctl.use_imm = 1'b1; ctl.illegal = 1'b0;
      end
      OPC_PCREL: begin
        ctl.kind = K_ADD; ctl.use_imm = 1'b1; ctl.use_pc = 1'b1; ctl.illegal = 1'b0;
      end
      default: ;
    endcase
    if (ctl.illegal) ctl.kind = K_NONE;
  end
endmodule

// File: rtl/rv_exec_core.sv
module rv_exec_core
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_ctl_t        ctl,
  input  logic [XLEN-1:0] a_in,
  input  logic [XLEN-1:0] b_in,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] result
);
  localparam int SHW  = $clog2(XLEN);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] opa, opb, raw, a_zx, a_sx, shift_src;
  logic [SHW-1:0]  amt;

  assign opa  = ctl.use_pc  ? pc  : a_in;
  assign opb  = ctl.use_imm ? imm : b_in;
  assign a_zx = {{HALF{1'b0}}, a_in[HALF-1:0]};
  assign a_sx = {{HALF{a_in[HALF-1]}}, a_in[HALF-1:0]};
  assign amt  = ctl.word ? {1'b0, opb[SHW-2:0]} : opb[SHW-1:0];
  assign shift_src = !ctl.word ? opa : (ctl.kind == K_SRA ? a_sx : a_zx);

  always_comb begin
    case (ctl.kind)
      K_ADD:  raw = opa + opb;
      K_SUB:  raw = opa - opb;
      K_SLL:  raw = opa << amt;
      K_SLT:  raw = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
      K_SLTU: raw = {{(XLEN-1){1'b0}}, opa < opb};
      K_XOR:  raw = opa ^ opb;
      K_SRL:  raw = shift_src >> amt;
      K_SRA:  raw = $unsigned($signed(shift_src) >>> amt);
      K_OR:   raw = opa | opb;
      K_AND:  raw = opa & opb;
      K_PASS: raw = opb;
      default: raw = '0;
    endcase
  end

  assign result = ctl.word ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
endmodule

// File: rtl/rv_exec_unit.sv
module rv_exec_unit
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [6:0]      op_code,
  input  logic [2:0]      op_minor,
  input  logic [6:0]      op_ext,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] pc,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            res_illegal
);
  alu_ctl_t        ctl;
  logic [XLEN-1:0] comb_res;

  rv_exec_decode #(.XLEN(XLEN)) u_dec (
    .code(op_code), .minor(op_minor), .ext(op_ext), .imm(imm), .ctl(ctl)
  );

  rv_exec_core #(.XLEN(XLEN)) u_core (
    .ctl(ctl), .a_in(src_a), .b_in(src_b), .imm(imm), .pc(pc), .result(comb_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data    <= comb_res;
        res_illegal <= ctl.illegal;
      end
    end
  end
endmodule

// File: rtl/rv_exec_checker.sv
module rv_exec_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [6:0]      op_code,
  input logic [2:0]      op_minor,
  input logic [6:0]      op_ext,
  input logic [XLEN-1:0] imm,
  input logic            res_valid,
  input logic [XLEN-1:0] res_data,
  input logic            res_illegal
);
  localparam int HALF = XLEN / 2;

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  assert_slt_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 7'h33 && op_ext == 7'h00 && (op_minor == 3'd2 || op_minor == 3'd3))
      |=> res_data[XLEN-1:1] == '0);

  assert_word_sext_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 7'h1b || op_code == 7'h3b))
      |=> res_data[XLEN-1:HALF] == {HALF{res_data[HALF-1]}});

  assert_upper_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 7'h37) |=> (res_data == $past(imm) && !res_illegal));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_illegal) |-> res_data == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(res_data) && $stable(res_illegal)));
endmodule

bind rv_exec_unit rv_exec_checker #(.XLEN(XLEN)) i_rv_exec_checker (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_minor(op_minor), .op_ext(op_ext), .imm(imm), .res_valid(res_valid),
  .res_data(res_data), .res_illegal(res_illegal)
);

// File: tb/test_rv_exec_unit.sv
module test_rv_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [6:0]  op_code = '0;
  logic [2:0]  op_minor = '0;
  logic [6:0]  op_ext = '0;
  logic [63:0] src_a = '0, src_b = '0, imm = '0, pc = '0;
  logic        res_valid, res_illegal;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] val;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t last_exp;

  always #10 clk = ~clk;

  rv_exec_unit i_rv_exec_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_minor(op_minor), .op_ext(op_ext), .src_a(src_a), .src_b(src_b),
    .imm(imm), .pc(pc), .res_valid(res_valid), .res_data(res_data),
    .res_illegal(res_illegal)
  );

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [6:0] c, input logic [2:0] f3,
      input logic [6:0] f7, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] i, input logic [63:0] p);
    exp_t e;
    logic [31:0] w;
    e.val = '0; e.ill = 1'b0; e.tag = "";
    if (c == 7'h13) begin
      case (f3)
        0: e.val = a + i;
        1: if (i[11:6] == 0) e.val = a << i[5:0]; else e.ill = 1;
        2: e.val = {63'd0, $signed(a) < $signed(i)};
        3: e.val = {63'd0, a < i};
        4: e.val = a ^ i;
        5: if (i[11:6] == 6'h00) e.val = a >> i[5:0];
           else if (i[11:6] == 6'h10) e.val = $unsigned($signed(a) >>> i[5:0]);
           else e.ill = 1;
        6: e.val = a | i;
        default: e.val = a & i;
      endcase
    end else if (c == 7'h33) begin
      if (f7 == 0) begin
        case (f3)
          0: e.val = a + b;
          1: e.val = a << b[5:0];
          2: e.val = {63'd0, $signed(a) < $signed(b)};
          3: e.val = {63'd0, a < b};
          4: e.val = a ^ b;
          5: e.val = a >> b[5:0];
          6: e.val = a | b;
          default: e.val = a & b;
        endcase
      end else if (f7 == 7'h20 && f3 == 0) e.val = a - b;
      else if (f7 == 7'h20 && f3 == 5) e.val = $unsigned($signed(a) >>> b[5:0]);
      else e.ill = 1;
    end else if (c == 7'h1b) begin
      if (f3 == 0) e.val = sx32(a[31:0] + i[31:0]);
      else if (f3 == 1 && i[11:5] == 0) e.val = sx32(a[31:0] << i[4:0]);
      else if (f3 == 5 && i[11:5] == 0) e.val = sx32(a[31:0] >> i[4:0]);
      else if (f3 == 5 && i[11:5] == 7'h20) begin
        w = $unsigned($signed(a[31:0]) >>> i[4:0]); e.val = sx32(w);
      end else e.ill = 1;
    end else if (c == 7'h3b) begin
      if (f3 == 0 && f7 == 0) e.val = sx32(a[31:0] + b[31:0]);
      else if (f3 == 0 && f7 == 7'h20) e.val = sx32(a[31:0] - b[31:0]);
      else if (f3 == 1 && f7 == 0) e.val = sx32(a[31:0] << b[4:0]);
      else if (f3 == 5 && f7 == 0) e.val = sx32(a[31:0] >> b[4:0]);
      else if (f3 == 5 && f7 == 7'h20) begin
        w = $unsigned($signed(a[31:0]) >>> b[4:0]); e.val = sx32(w);
      end else e.ill = 1;
    end else if (c == 7'h37) e.val = i;
    else if (c == 7'h17) e.val = p + i;
    else e.ill = 1;
    return e;
  endfunction

  task automatic issue(input logic [6:0] c, input logic [2:0] f3, input logic [6:0] f7,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] i,
      input logic [63:0] p, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_minor = f3; op_ext = f7;
    src_a = a; src_b = b; imm = i; pc = p;
    e = model(c, f3, f7, a, b, i, p);
    e.tag = tag;
    sb.push_back(e);
    last_exp = e;
  endtask

  task automatic check_imm(input logic [63:0] got, input logic [63:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
      op_code = 7'h7f; src_a = 64'hdead_beef_0000_1111;
    end
  endtask

  // Monitor: compares produced results in order against the scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected result %h expected none", res_data);
      end else begin
        e = sb.pop_front();
        if (res_data !== e.val || res_illegal !== e.ill) begin
          fails++;
          $display("FAIL %s: got %h/%b expected %h/%b", e.tag, res_data, res_illegal, e.val, e.ill);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [6:0]  codes [6];
    codes[0] = 7'h13; codes[1] = 7'h33; codes[2] = 7'h1b;
    codes[3] = 7'h3b; codes[4] = 7'h37; codes[5] = 7'h17;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_imm({63'd0, res_valid}, 64'd0, "R1 valid");
    check_imm(res_data, 64'd0, "R1 data");
    check_imm({63'd0, res_illegal}, 64'd0, "R1 illegal");
    rst = 1'b0;

    // R2 immediate family
    issue(7'h13, 0, 0, 64'd5, 0, -64'sd7, 0, "R2");
    issue(7'h13, 4, 0, 64'hff00, 0, 64'h0f0f, 0, "R2");
    issue(7'h13, 6, 0, 64'h1, 0, 64'hfffffffffffff800, 0, "R2");
    issue(7'h13, 7, 0, 64'h123456789, 0, 64'h7ff, 0, "R2");
    issue(7'h13, 2, 0, -64'sd3, 0, 64'd1, 0, "R2/R6 slti");
    issue(7'h13, 3, 0, 64'd3, 0, -64'sd1, 0, "R6 sltiu huge");
    issue(7'h13, 3, 0, -64'sd2, 0, -64'sd1, 0, "R6 sltiu");
    // R3 register family
    issue(7'h33, 0, 7'h20, 64'd3, 64'd10, 0, 0, "R3 sub");
    issue(7'h33, 5, 7'h20, 64'h8000_0000_0000_0000, 64'd63, 0, 0, "R3 sra");
    issue(7'h33, 2, 0, 64'd2, -64'sd1, 0, 0, "R3/R6 slt");
    issue(7'h33, 4, 7'h20, 64'd2, 64'd1, 0, 0, "R3 bad ext");
    // R4 six-bit amounts, upper rs2 bits ignored
    issue(7'h33, 1, 0, 64'd1, 64'hffc0 + 64'd33, 0, 0, "R4 sll");
    issue(7'h33, 5, 0, 64'h8000_0000_0000_0000, 64'd40, 0, 0, "R4 srl");
    issue(7'h13, 1, 0, 64'd1, 0, 64'd63, 0, "R4 slli");
    // R5 immediate shift type bit and stray bits
    issue(7'h13, 5, 0, 64'hf000_0000_0000_0000, 0, 64'h400 | 64'd4, 0, "R5 srai");
    issue(7'h13, 5, 0, 64'hf000_0000_0000_0000, 0, 64'd4, 0, "R5 srli");
    issue(7'h13, 5, 0, 64'hf000_0000_0000_0000, 0, 64'h800 | 64'd4, 0, "R5 stray");
    issue(7'h13, 1, 0, 64'd1, 0, 64'h400 | 64'd2, 0, "R5 slli type");
    // R7 word family
    issue(7'h1b, 0, 0, 64'h1234_5678_7fff_ffff, 0, 64'd1, 0, "R7 addiw");
    issue(7'h3b, 0, 7'h20, 64'hffff_ffff_0000_0000, 64'd1, 0, 0, "R7 subw");
    issue(7'h3b, 1, 0, 64'd1, 64'd63, 0, 0, "R7 sllw 5-bit");
    issue(7'h3b, 5, 7'h20, 64'h0000_0000_8000_0000, 64'd4, 0, 0, "R7 sraw");
    issue(7'h3b, 5, 0, 64'hffff_ffff_8000_0000, 64'd0, 0, 0, "R7 srlw 0");
    issue(7'h1b, 5, 0, 64'h8000_0000, 0, 64'h400 | 64'd1, 0, "R7 sraiw");
    issue(7'h1b, 1, 0, 64'd1, 0, 64'h20, 0, "R7 slliw bit5");
    issue(7'h3b, 4, 0, 64'd1, 64'd1, 0, 0, "R7 xorw absent");
    // R8 upper and PC-relative
    issue(7'h37, 0, 0, 64'd9, 0, 64'hffff_ffff_8000_0000, 0, "R8 upper");
    issue(7'h17, 0, 0, 64'd9, 0, 64'h1000, 64'h8000_0ffc, "R8 pcrel");
    // R9 unknown opcode
    issue(7'h03, 0, 0, 64'd1, 64'd1, 64'd1, 0, "R9 opcode");
    issue(7'h33, 0, 7'h01, 64'd1, 64'd1, 0, 0, "R9 ext");
    // R10 hold while idle
    idle(3);
    check_imm({63'd0, res_valid}, 64'd0, "R10 valid");
    check_imm(res_data, last_exp.val, "R10 data");
    check_imm({63'd0, res_illegal}, {63'd0, last_exp.ill}, "R10 illegal");

    // Pseudo-random sweep over R2 R3 R7 R8 R9
    lf = 32'h1ace_b00c;
    for (int n = 0; n < 600; n++) begin
      logic [63:0] ra, rb, ri;
      logic [6:0]  c;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = {lf, ~lf[15:0], lf[31:16]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = {~lf, lf};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ri = {{52{lf[11]}}, lf[11:0]};
      c  = (lf[31:29] == 3'd7) ? lf[22:16] : codes[lf[28:26] % 6];
      issue(c, lf[14:12], (lf[25]) ? 7'h20 : (lf[24] ? lf[23:17] : 7'h00),
            ra, rb, ri, {rb[31:0], ra[31:0]}, "R2/R3/R7/R8/R9 sweep");
    end
    idle(4);
    check_imm(64'(sb.size()), 64'd0, "R1 drained");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule